// File: doc/BRIEF.md
# Backplane System Reset Controller

This block owns the reset state of a board that sits on a shared backplane. It watches a digital power-good level and the backplane's active-low supply-fail line. Whenever either reports trouble, it pulls the board-wide reset low at once. When both are healthy again, it holds that reset for a programmed minimum time before letting go. That release is synchronised to the local clock. A strap tells the block whether the board is the backplane's system controller. Only then does the power reset also appear on the backplane reset line, and only then does the block emit the clock-enable pulses used to source the backplane system clock.

Software can also reset the system by writing to one location in a 16-bit short address space. The block sees that write as a strobe with an address. A 12-bit switch value places the register block inside that space. The write stores nothing. It starts a stretched soft reset that drives both the board reset and the backplane reset, whatever the strap says.

The hold time is derived from the clock frequency in MHz and a hold time in microseconds. The defaults give 200 ms at 64 MHz. The soft pulse width and the decoded offset are parameters too.

Top module: `sysrst_ctrl`

## Requirements
- R1: When `pwr_good` is 0 or `bp_acfail_n` is 0, `sys_rst_n` goes to 0 without waiting for a clock edge and stays 0 while the condition lasts.
- R2: Once both `pwr_good` and `bp_acfail_n` are 1, `sys_rst_n` stays 0 for HOLD_CYCLES+1 rising edges. It goes to 1 on rising edge HOLD_CYCLES+2, where two edges are spent on synchronisation. HOLD_CYCLES = CLK_MHZ*HOLD_US.
- R3: A return of either failure indication during the hold clears the hold. The full HOLD_CYCLES+2 edges are counted again from the moment both inputs are healthy.
- R4: The power reset drives `bp_sysreset_n` to 0 only when `sysctl_en` is 1. With `sysctl_en` at 0, `bp_sysreset_n` stays 1 through power loss and the hold.
- R5: A write is decoded when `bus_wr` is 1, `bus_addr[15:4]` equals `base_sw`, and `bus_addr[3:0]` equals RST_OFS (default 4'hC). It drives both `sys_rst_n` and `bp_sysreset_n` to 0 from that rising edge for exactly SOFT_CYCLES clock cycles. This happens for either value of `sysctl_en`.
- R6: A write whose upper 12 address bits differ from `base_sw`, or whose low 4 bits differ from RST_OFS, changes no output.
- R7: A decoded write arriving while a soft pulse is running restarts the pulse. Both outputs then stay 0 for SOFT_CYCLES cycles counted from the later write.
- R8: Decoded writes made while the power reset is held are ignored. No soft pulse follows the release.
- R9: With `sysctl_en` at 1 and the power reset released, `sysclk_ce` is a one-cycle pulse every CLK_MHZ/SYSCLK_MHZ cycles (4 with defaults). With `sysctl_en` at 0, or during power reset, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| pwr_good | input | 1 | Supply healthy level, 1 = good |
| bp_acfail_n | input | 1 | Backplane supply-fail, active low |
| sysctl_en | input | 1 | Strap: board is backplane system controller |
| bus_wr | input | 1 | Write strobe of a short-space access, one cycle |
| bus_addr | input | 16 | Short-space address of the access |
| base_sw | input | 12 | Switch setting for the register block base (upper address bits) |
| sys_rst_n | output | 1 | Board system reset, active low |
| bp_sysreset_n | output | 1 | Backplane reset, active low |
| sysclk_ce | output | 1 | Clock enable for the backplane system clock |

## Verification
Power is cycled through both failure inputs. Each input is dropped between clock edges, which separates an asynchronous assertion from a clocked one. A failure is also repeated part-way through the hold, which shows whether the count restarts or resumes. Writes are tried at the matching address, with a wrong base, and with a wrong offset, each with the strap set and cleared. This pattern separates the address decode from the strap gating. A second write during a running pulse separates retriggering from ignoring, and a write during the power hold checks that the hold masks writes. Clock-enable pulses are counted and spaced with the strap on and off.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_HOLD = 2'd1,
        PM_RUN  = 2'd2
    } pm_state_e;

    function automatic logic addr_match(
        input logic [15:0] addr,
        input logic [11:0] base,
        input logic [3:0]  ofs
    );
        return (addr[15:4] == base) && (addr[3:0] == ofs);
    endfunction

endpackage

// File: rtl/sysrst_pwr_mon.sv
module sysrst_pwr_mon
    import sysrst_pkg::*;
#(
    parameter int HOLD_CYCLES = 64
) (
    input  logic clk,
    input  logic arst_n,
    output logic por_ok
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [1:0]  sync;
        pm_state_e   state;
        logic [CW-1:0] cnt;
    } pm_regs_t;

    pm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.sync = {r_q.sync[0], 1'b1};
        case (r_q.state)
            PM_OFF: begin
                if (r_q.sync[1]) begin
                    r_d.state = PM_HOLD;
                    r_d.cnt   = CW'(1);
                end
            end
            PM_HOLD: begin
                if (r_q.cnt == HOLD_LAST) begin
                    r_d.state = PM_RUN;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            PM_RUN:  r_d.state = PM_RUN;
            default: r_d.state = PM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q <= '{sync: 2'b00, state: PM_OFF, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign por_ok = (r_q.state == PM_RUN);

    // R2: once released the reset stays released while power is healthy
    a_r2_run_sticky: assert property (@(posedge clk) disable iff (!arst_n)
        (r_q.state == PM_RUN) |=> (r_q.state == PM_RUN));

    // R2: no release before the hold count has reached its end
    a_r2_min_hold: assert property (@(posedge clk) disable iff (!arst_n)
        (r_q.state == PM_HOLD && r_q.cnt != HOLD_LAST) |=> !por_ok);

    // R2: counting only starts after the synchroniser has filled
    a_r2_sync_first: assert property (@(posedge clk) disable iff (!arst_n)
        (r_q.state == PM_OFF) |=> (r_q.state != PM_RUN));

endmodule

// File: rtl/sysrst_soft.sv
module sysrst_soft
    import sysrst_pkg::*;
#(
    parameter int         ADDR_W      = 16,
    parameter int         SW_W        = 12,
    parameter logic [3:0] RST_OFS     = 4'hC,
    parameter int         SOFT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              block,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SW_W-1:0]   base_sw,
    output logic              active
);
    localparam int SCW = $clog2(SOFT_CYCLES + 1);
    localparam logic [SCW-1:0] SOFT_LOAD = SCW'(SOFT_CYCLES);

    typedef struct packed {
        logic [SCW-1:0] cnt;
    } sr_regs_t;

    sr_regs_t r_d, r_q;
    logic     hit;

    assign hit = wr && !block && addr_match(addr, base_sw, RST_OFS);

    always_comb begin
        r_d = r_q;
        if (hit) begin
            r_d.cnt = SOFT_LOAD;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - SCW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q <= '{cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign active = (r_q.cnt != '0);

    // R5 / R7: a decoded write (re)starts a full-width pulse
    a_r7_reload: assert property (@(posedge clk) disable iff (!arst_n)
        hit |=> (r_q.cnt == SOFT_LOAD));

    // R6 / R8: with no decoded write an idle stretcher stays idle
    a_r6_idle_stays: assert property (@(posedge clk) disable iff (!arst_n)
        (!active && !hit) |=> !active);

    // R8: writes during power hold never start a pulse
    a_r8_blocked: assert property (@(posedge clk) disable iff (!arst_n)
        (block && !active) |=> !active);

endmodule

// File: rtl/sysrst_clk_en.sv
module sysrst_clk_en #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic enable,
    output logic ce
);
    generate
        if (RATIO <= 1) begin : g_every
            typedef struct packed {
                logic ce;
            } ce_regs_t;
            ce_regs_t r_d, r_q;

            always_comb begin
                r_d.ce = enable;
            end

            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) r_q <= '{ce: 1'b0};
                else         r_q <= r_d;
            end

            assign ce = r_q.ce;
        end else begin : g_div
            localparam int DW = $clog2(RATIO);
            localparam logic [DW-1:0] DIV_LAST = DW'(RATIO - 1);

            typedef struct packed {
                logic [DW-1:0] div;
                logic          ce;
            } ce_regs_t;
            ce_regs_t r_d, r_q;

            always_comb begin
                r_d = r_q;
                r_d.ce = 1'b0;
                if (!enable) begin
                    r_d.div = '0;
                end else if (r_q.div == DIV_LAST) begin
                    r_d.div = '0;
                    r_d.ce  = 1'b1;
                end else begin
                    r_d.div = r_q.div + DW'(1);
                end
            end

            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) r_q <= '{div: '0, ce: 1'b0};
                else         r_q <= r_d;
            end

            assign ce = r_q.ce;

            // R9: each enable pulse lasts a single cycle
            a_r9_single_pulse: assert property (@(posedge clk) disable iff (!arst_n)
                ce |=> !ce);
        end
    endgenerate

    // R9: no pulse follows a cycle without enable
    a_r9_gated: assert property (@(posedge clk) disable iff (!arst_n)
        !enable |=> !ce);

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl #(
    parameter int         CLK_MHZ     = 64,
    parameter int         SYSCLK_MHZ  = 16,
    parameter int         HOLD_US     = 200_000,
    parameter int         SOFT_CYCLES = 8,
    parameter logic [3:0] RST_OFS     = 4'hC
) (
    input  logic        clk,
    input  logic        pwr_good,
    input  logic        bp_acfail_n,
    input  logic        sysctl_en,
    input  logic        bus_wr,
    input  logic [15:0] bus_addr,
    input  logic [11:0] base_sw,
    output logic        sys_rst_n,
    output logic        bp_sysreset_n,
    output logic        sysclk_ce
);
    localparam int HOLD_CYCLES = CLK_MHZ * HOLD_US;
    localparam int CE_RATIO    = CLK_MHZ / SYSCLK_MHZ;

    logic arst_n;
    logic por_ok;
    logic soft_act;

    assign arst_n = pwr_good & bp_acfail_n;

    sysrst_pwr_mon #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_pwr_mon (
        .clk    (clk),
        .arst_n (arst_n),
        .por_ok (por_ok)
    );

    sysrst_soft #(
        .ADDR_W     (16),
        .SW_W       (12),
        .RST_OFS    (RST_OFS),
        .SOFT_CYCLES(SOFT_CYCLES)
    ) u_soft (
        .clk     (clk),
        .arst_n  (arst_n),
        .block   (!por_ok),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .base_sw (base_sw),
        .active  (soft_act)
    );

    sysrst_clk_en #(
        .RATIO(CE_RATIO)
    ) u_clk_en (
        .clk    (clk),
        .arst_n (arst_n),
        .enable (sysctl_en & por_ok),
        .ce     (sysclk_ce)
    );

    assign sys_rst_n     = por_ok & ~soft_act;
    assign bp_sysreset_n = ~((~por_ok & sysctl_en) | soft_act);

    // R1: a failed supply always holds the board in reset
    a_r1_fail_holds: assert property (@(posedge clk)
        !arst_n |-> !sys_rst_n);

    // R4: without the strap the power reset never reaches the backplane
    a_r4_strap_gates: assert property (@(posedge clk) disable iff (!arst_n)
        (!sysctl_en && !soft_act) |-> bp_sysreset_n);

    // R5: a soft pulse reaches both resets regardless of the strap
    a_r5_soft_both: assert property (@(posedge clk) disable iff (!arst_n)
        soft_act |-> (!sys_rst_n && !bp_sysreset_n));

    // R9: no clock enable while the board is in power reset
    a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
        !por_ok |-> !sysclk_ce);

endmodule

// File: tb/sysrst_ctrl_tb.sv
module sysrst_ctrl_tb;
    localparam int CLK_MHZ = 64;
    localparam int SYS_MHZ = 16;
    localparam int HOLD_US = 1;
    localparam int HOLD    = CLK_MHZ * HOLD_US;
    localparam int SOFT    = 8;
    localparam int RATIO   = CLK_MHZ / SYS_MHZ;
    localparam logic [3:0]  OFS  = 4'hC;
    localparam logic [11:0] BASE = 12'hA5C;

    logic        clk = 1'b0;
    logic        pwr_good = 1'b0;
    logic        bp_acfail_n = 1'b1;
    logic        sysctl_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [11:0] base_sw = BASE;
    logic        sys_rst_n, bp_sysreset_n, sysclk_ce;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sysrst_ctrl #(
        .CLK_MHZ(CLK_MHZ), .SYSCLK_MHZ(SYS_MHZ), .HOLD_US(HOLD_US),
        .SOFT_CYCLES(SOFT), .RST_OFS(OFS)
    ) u_dut (
        .clk(clk), .pwr_good(pwr_good), .bp_acfail_n(bp_acfail_n),
        .sysctl_en(sysctl_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .base_sw(base_sw), .sys_rst_n(sys_rst_n),
        .bp_sysreset_n(bp_sysreset_n), .sysclk_ce(sysclk_ce)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(logic [15:0] a);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0;
    endtask

    // bring power up from the current state; returns with reset released
    task automatic power_up();
        @(negedge clk);
        pwr_good = 1'b0;
        edges(2);
        pwr_good = 1'b1; bp_acfail_n = 1'b1;
        edges(HOLD + 2);
    endtask

    task automatic t_reset_state();
        check("R1 reset state sys_rst_n", sys_rst_n, 0);
        check("R4 reset state bp_sysreset_n", bp_sysreset_n, 0);
        check("R9 reset state sysclk_ce", sysclk_ce, 0);
    endtask

    task automatic t_powerup_timing();
        @(negedge clk);
        pwr_good = 1'b1;
        edges(HOLD + 1);
        check("R2 still held after HOLD+1 edges", sys_rst_n, 0);
        check("R4 backplane held with strap", bp_sysreset_n, 0);
        edges(1);
        check("R2 released at HOLD+2 edges", sys_rst_n, 1);
        check("R4 backplane released with strap", bp_sysreset_n, 1);
    endtask

    task automatic t_async_fail();
        @(negedge clk);
        #1 pwr_good = 1'b0;
        #0.5;
        check("R1 async assert on pwr_good", sys_rst_n, 0);
        power_up();
        @(negedge clk);
        #1 bp_acfail_n = 1'b0;
        #0.5;
        check("R1 async assert on acfail", sys_rst_n, 0);
        check("R1 backplane follows with strap", bp_sysreset_n, 0);
        edges(3);
        check("R1 held while acfail low", sys_rst_n, 0);
        bp_acfail_n = 1'b1;
        edges(HOLD + 2);
        check("R2 release after acfail clears", sys_rst_n, 1);
    endtask

    task automatic t_hold_restart();
        @(negedge clk);
        pwr_good = 1'b0;
        edges(2);
        pwr_good = 1'b1;
        edges(HOLD / 2);
        bp_acfail_n = 1'b0;
        edges(2);
        bp_acfail_n = 1'b1;
        edges(HOLD + 1);
        check("R3 hold restarted, still low", sys_rst_n, 0);
        edges(1);
        check("R3 release after full restart", sys_rst_n, 1);
    endtask

    task automatic t_no_strap();
        int bp_low = 0;
        sysctl_en = 1'b0;
        @(negedge clk);
        pwr_good = 1'b0;
        edges(2);
        pwr_good = 1'b1;
        for (int i = 0; i < HOLD + 2; i++) begin
            if (!bp_sysreset_n) bp_low++;
            edges(1);
        end
        check("R4 backplane untouched without strap", bp_low, 0);
        check("R2 board released without strap", sys_rst_n, 1);
    endtask

    task automatic measure_soft(string req, int exp_low);
        int lows = 0;
        int bp_lows = 0;
        for (int i = 0; i < exp_low + 4; i++) begin
            if (!sys_rst_n) lows++;
            if (!bp_sysreset_n) bp_lows++;
            edges(1);
        end
        check({req, " sys_rst_n low cycles"}, lows, exp_low);
        check({req, " bp_sysreset_n low cycles"}, bp_lows, exp_low);
    endtask

    task automatic t_soft(logic strap);
        sysctl_en = strap;
        write({BASE, OFS});
        measure_soft(strap ? "R5 strap=1" : "R5 strap=0", SOFT);
    endtask

    task automatic t_miss();
        int lows = 0;
        write({BASE ^ 12'h001, OFS});
        write({BASE, OFS ^ 4'h1});
        write({12'h000, 4'h0});
        for (int i = 0; i < SOFT + 2; i++) begin
            if (!sys_rst_n || !bp_sysreset_n) lows++;
            edges(1);
        end
        check("R6 mismatched writes ignored", lows, 0);
    endtask

    task automatic t_retrigger();
        int lows = 0;
        write({BASE, OFS});
        edges(3);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {BASE, OFS};
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0;
        edges(SOFT - 1);
        check("R7 still low before restarted end", sys_rst_n, 0);
        edges(1);
        check("R7 released after restarted width", sys_rst_n, 1);
        for (int i = 0; i < 3; i++) begin
            if (!sys_rst_n) lows++;
            edges(1);
        end
        check("R7 no further pulse", lows, 0);
    endtask

    task automatic t_blocked();
        int lows = 0;
        @(negedge clk);
        pwr_good = 1'b0;
        edges(2);
        pwr_good = 1'b1;
        edges(4);
        write({BASE, OFS});
        edges(HOLD);
        check("R8 released despite write in hold", sys_rst_n, 1);
        for (int i = 0; i < SOFT + 2; i++) begin
            if (!sys_rst_n) lows++;
            edges(1);
        end
        check("R8 no soft pulse after release", lows, 0);
    endtask

    task automatic t_clock_enable();
        int cnt = 0;
        int last = -1;
        int bad_gap = 0;
        sysctl_en = 1'b1;
        edges(2);
        for (int i = 0; i < 10 * RATIO; i++) begin
            if (sysclk_ce) begin
                if (last >= 0 && i - last != RATIO) bad_gap++;
                last = i;
                cnt++;
            end
            edges(1);
        end
        check("R9 pulse count with strap", cnt, 10);
        check("R9 pulse spacing", bad_gap, 0);
        sysctl_en = 1'b0;
        edges(1);
        cnt = 0;
        for (int i = 0; i < 4 * RATIO; i++) begin
            if (sysclk_ce) cnt++;
            edges(1);
        end
        check("R9 no pulse without strap", cnt, 0);
        sysctl_en = 1'b1;
        @(negedge clk);
        pwr_good = 1'b0;
        cnt = 0;
        for (int i = 0; i < 4 * RATIO; i++) begin
            if (sysclk_ce) cnt++;
            edges(1);
        end
        check("R9 no pulse in power reset", cnt, 0);
        pwr_good = 1'b1;
        edges(HOLD + 2);
    endtask

    initial begin
        #1;
        t_reset_state();
        t_powerup_timing();
        t_async_fail();
        t_hold_restart();
        t_no_strap();
        t_soft(1'b0);
        t_soft(1'b1);
        t_miss();
        t_retrigger();
        t_blocked();
        t_clock_enable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50_000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule